// File: doc/BRIEF.md
# Programmable Interval Timer with Reload

This block is a timer peripheral that sits on a byte-wide register bus with an 8-bit address, separate read and write strobes and 8-bit data in each direction. It holds four registers. The first is a free-running divider that counts every clock. The second is a counter that steps at a rate chosen by software. The third is a reload value. The fourth is a control register that holds an enable bit and a two-bit rate select.

Counter steps are timed by an internal prescaler. The prescaler is cleared while the timer is disabled and runs only while it is enabled. When a step would carry the counter beyond its all-ones value, the counter takes the reload value instead of wrapping to zero. The same event produces a one-clock interrupt pulse and sets a sticky pending flag, which stays set until an acknowledge input clears it. Every clock counts as one timer tick.

Top module: `interval_timer`

## Requirements
- R1: The registers decode at addresses 0x04 (divider), 0x05 (counter), 0x06 (reload) and 0x07 (control). A read at any other address returns 0xFF, and a write at any other address changes nothing.
- R2: The divider increases by one every clock and wraps from 0xFF to 0x00. Any write to the divider address sets it to zero whatever the data, and it counts up again from the next clock.
- R3: The counter steps only while control bit 2 (enable) is 1. While enable is 0 the counter holds its value and the prescaler is held at zero.
- R4: Control bits 1:0 select the step period: 00 gives one step every 1024 clocks, 01 every 16, 10 every 64 and 11 every 256. The first step lands on the clock edge that is exactly one period after the edge of the write that set enable.
- R5: A step taken while the counter holds 0xFF loads the counter with the reload register value.
- R6: `irq_pulse` is high for exactly one cycle, in the cycle after the edge at which an overflow occurs.
- R7: `irq_pending` is set by an overflow and stays set until `irq_ack` is sampled high. When an overflow and an acknowledge fall on the same edge, the set wins.
- R8: A bus write to the counter on the same edge as a step stores the written value and signals no overflow.
- R9: A read of the control register returns 1 in bits 7:3. Writes to bits 7:3 are ignored and leave enable and rate unchanged.
- R10: Reset clears the divider, counter, reload, control, prescaler and read data to zero and holds both interrupt outputs low.
- R11: `bus_rdata` is registered. It shows the addressed register one cycle after `bus_re` and holds its value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; each rising edge is one timer tick |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| irq_ack | input | 1 | Clears the pending interrupt flag |
| irq_pulse | output | 1 | One-cycle interrupt request on overflow |
| irq_pending | output | 1 | Sticky interrupt request flag |

## Verification
The assertions check the following on every cycle:
- the divider moves by one per clock or clears on a write;
- the counter holds while no step is taken and moves up by one on an ordinary step;
- an overflow reloads the counter;
- a counter write takes priority over a step;
- the interrupt pulse lasts one cycle and is always covered by the pending flag;
- read data holds between reads.

Only the bench scenarios can show the following:
- that each rate code gives the right period, tested at the boundary of 1023 and 1024 clocks;
- that the first step comes exactly one period after enabling;
- that the interrupt lands on the expected cycle;
- that a write racing a step suppresses the overflow;
- that the set wins over a simultaneous acknowledge.

// File: rtl/timer_pkg.sv
`timescale 1ns/1ps
package timer_pkg;

  typedef enum logic [1:0] {
    RATE_1024 = 2'b00,
    RATE_16   = 2'b01,
    RATE_64   = 2'b10,
    RATE_256  = 2'b11
  } rate_e;

  typedef struct packed {
    logic  enable;
    rate_e rate;
  } ctrl_t;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/timer_divider.sv
`timescale 1ns/1ps
module timer_divider #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] div_q
);

  always_ff @(posedge clk) begin
    if (rst || clr) div_q <= '0;
    else            div_q <= div_q + W'(1);
  end

  // R2: one per clock, wrapping
  a_r2_count: assert property (@(posedge clk) disable iff (rst)
    !clr |=> div_q == $past(div_q) + W'(1));
  // R2: any write clears
  a_r2_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> div_q == '0);

endmodule

// File: rtl/timer_prescaler.sv
`timescale 1ns/1ps
module timer_prescaler
  import timer_pkg::*;
#(
  parameter int SH0 = 10,
  parameter int SH1 = 4,
  parameter int SH2 = 6,
  parameter int SH3 = 8
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  enable,
  input  rate_e rate,
  output logic  step
);

  localparam int PW = max_of4(SH0, SH1, SH2, SH3);
  localparam int SH_TAB [4] = '{SH0, SH1, SH2, SH3};

  logic [PW-1:0] pre_q;
  logic [PW-1:0] lim [4];
  logic [PW-1:0] limit;

  for (genvar gi = 0; gi < 4; gi++) begin : g_lim
    assign lim[gi] = PW'((32'd1 << SH_TAB[gi]) - 32'd1);
  end

  assign limit = lim[rate];
  assign step  = enable && (pre_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || !enable) pre_q <= '0;
    else if (step)      pre_q <= '0;
    else                pre_q <= pre_q + PW'(1);
  end

  // R3: prescaler parked at zero while disabled
  a_r3_presc_idle: assert property (@(posedge clk) disable iff (rst)
    !enable |=> pre_q == '0);
  // R4: after a step the count restarts
  a_r4_restart: assert property (@(posedge clk) disable iff (rst)
    step |=> pre_q == '0);

endmodule

// File: rtl/timer_counter.sv
`timescale 1ns/1ps
module timer_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         cnt_we,
  input  logic         mod_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] mod_q,
  output logic         ovf
);

  logic at_top;
  assign at_top = (cnt_q == '1);
  assign ovf    = step && !cnt_we && at_top;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (cnt_we) cnt_q <= wdata;
    else if (ovf)    cnt_q <= mod_q;
    else if (step)   cnt_q <= cnt_q + W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)         mod_q <= '0;
    else if (mod_we) mod_q <= wdata;
  end

  // R3: no step, no write -> hold
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!step && !cnt_we) |=> $stable(cnt_q));
  // R4: ordinary step adds one
  a_r4_inc: assert property (@(posedge clk) disable iff (rst)
    (step && !cnt_we && cnt_q != '1) |=> cnt_q == $past(cnt_q) + W'(1));
  // R5: overflow reloads from the modulo register
  a_r5_reload: assert property (@(posedge clk) disable iff (rst)
    (step && !cnt_we && cnt_q == '1) |=> cnt_q == $past(mod_q));
  // R8: bus write wins over a step
  a_r8_write_wins: assert property (@(posedge clk) disable iff (rst)
    cnt_we |=> cnt_q == $past(wdata));

endmodule

// File: rtl/interval_timer.sv
`timescale 1ns/1ps
module interval_timer
  import timer_pkg::*;
#(
  parameter int             ADDR_W   = 8,
  parameter int             DATA_W   = 8,
  parameter logic [7:0]     ADDR_DIV = 8'h04,
  parameter logic [7:0]     ADDR_CNT = 8'h05,
  parameter logic [7:0]     ADDR_MOD = 8'h06,
  parameter logic [7:0]     ADDR_CTL = 8'h07,
  parameter int             RATE_SH0 = 10,
  parameter int             RATE_SH1 = 4,
  parameter int             RATE_SH2 = 6,
  parameter int             RATE_SH3 = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              irq_ack,
  output logic              irq_pulse,
  output logic              irq_pending
);

  localparam int CW = $bits(ctrl_t);

  logic hit_div, hit_cnt, hit_mod, hit_ctl, hit_any;
  logic step, ovf;
  logic [DATA_W-1:0] div_q, cnt_q, mod_q, rd_d;
  ctrl_t ctrl_q;

  assign hit_div = (bus_addr == ADDR_W'(ADDR_DIV));
  assign hit_cnt = (bus_addr == ADDR_W'(ADDR_CNT));
  assign hit_mod = (bus_addr == ADDR_W'(ADDR_MOD));
  assign hit_ctl = (bus_addr == ADDR_W'(ADDR_CTL));
  assign hit_any = hit_div | hit_cnt | hit_mod | hit_ctl;

  timer_divider #(.W(DATA_W)) u_div (
    .clk   (clk),
    .rst   (rst),
    .clr   (bus_we && hit_div),
    .div_q (div_q)
  );

  timer_prescaler #(
    .SH0(RATE_SH0), .SH1(RATE_SH1), .SH2(RATE_SH2), .SH3(RATE_SH3)
  ) u_pre (
    .clk    (clk),
    .rst    (rst),
    .enable (ctrl_q.enable),
    .rate   (ctrl_q.rate),
    .step   (step)
  );

  timer_counter #(.W(DATA_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .step   (step),
    .cnt_we (bus_we && hit_cnt),
    .mod_we (bus_we && hit_mod),
    .wdata  (bus_wdata),
    .cnt_q  (cnt_q),
    .mod_q  (mod_q),
    .ovf    (ovf)
  );

  always_ff @(posedge clk) begin
    if (rst)                    ctrl_q <= '0;
    else if (bus_we && hit_ctl) ctrl_q <= ctrl_t'(bus_wdata[CW-1:0]);
  end

  always_comb begin
    rd_d = '1;
    if (hit_div)      rd_d = div_q;
    else if (hit_cnt) rd_d = cnt_q;
    else if (hit_mod) rd_d = mod_q;
    else if (hit_ctl) rd_d = {{(DATA_W-CW){1'b1}}, ctrl_q};
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_pulse   <= 1'b0;
      irq_pending <= 1'b0;
    end else begin
      irq_pulse <= ovf;
      if (ovf)          irq_pending <= 1'b1;
      else if (irq_ack) irq_pending <= 1'b0;
    end
  end

  // R6: pulse never lasts two cycles
  a_r6_single: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |=> !irq_pulse);
  // R7: pulse is always mirrored by the sticky flag
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> irq_pending);
  // R7: flag holds without acknowledge
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (irq_pending && !irq_ack) |=> irq_pending);
  // R9: upper control bits read as ones
  a_r9_ctl_read: assert property (@(posedge clk) disable iff (rst)
    (bus_re && hit_ctl) |=> bus_rdata[DATA_W-1:CW] == '1);
  // R1: unmapped reads return all ones
  a_r1_unmapped: assert property (@(posedge clk) disable iff (rst)
    (bus_re && !hit_any) |=> bus_rdata == '1);
  // R11: read data holds without a read strobe
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> $stable(bus_rdata));

endmodule

// File: tb/interval_timer_tb.sv
`timescale 1ns/1ps
module interval_timer_tb;

  localparam logic [7:0] A_DIV = 8'h04, A_CNT = 8'h05, A_MOD = 8'h06, A_CTL = 8'h07;

  logic clk = 1'b0;
  logic rst;
  logic [7:0] bus_addr, bus_wdata, bus_rdata;
  logic bus_we, bus_re, irq_ack, irq_pulse, irq_pending;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  logic rd_seen = 1'b0;
  logic [7:0] last_rd = 8'h00;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } rd_item_t;
  rd_item_t exp_q[$];

  interval_timer u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .irq_ack(irq_ack), .irq_pulse(irq_pulse), .irq_pending(irq_pending)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc     <= cyc + 1;
    rd_seen <= bus_re;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pop expected read results and compare
  initial begin
    forever begin
      @(negedge clk);
      if (rd_seen === 1'b1) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "scoreboard underflow", bus_rdata, 0);
        end else begin
          rd_item_t it;
          it = exp_q.pop_front();
          last_rd = it.exp;
          chk(bus_rdata === it.exp, it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  // driver tasks: entered and left at a falling edge
  task automatic wr(input logic [7:0] a, input logic [7:0] d, output int edge_n);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    edge_n = cyc;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    rd_item_t it;
    it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // load counter, enable with a rate, idle, disable, read back
  task automatic run_rate(input logic [1:0] sel, input int period, input logic [7:0] start,
                          input int n, input string tag);
    int e, d, steps;
    wr(A_CNT, start, e);
    wr(A_CTL, {5'b0, 1'b1, sel}, e);
    idle(n);
    wr(A_CTL, {5'b0, 1'b0, sel}, d);
    steps = (d - e) / period;
    rd(A_CNT, 8'(int'(start) + steps), tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int r0, w, e, d;
    rst = 1'b1; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; bus_re = 1'b0; irq_ack = 1'b0;
    idle(5);
    rst = 1'b0;
    r0 = cyc;

    // R10: reset state
    chk(irq_pulse === 1'b0, "R10 irq_pulse after reset", irq_pulse, 0);
    chk(irq_pending === 1'b0, "R10 irq_pending after reset", irq_pending, 0);
    chk(bus_rdata === 8'h00, "R10 rdata after reset", bus_rdata, 0);
    rd(A_CNT, 8'h00, "R10 counter reset");
    rd(A_MOD, 8'h00, "R10 reload reset");
    rd(A_CTL, 8'hF8, "R10 control reset");

    // R2: divider counts from reset and wraps
    rd(A_DIV, 8'(cyc - r0), "R2 divider count");
    idle(300);
    rd(A_DIV, 8'(cyc - r0), "R2 divider wrap");
    wr(A_DIV, 8'hA5, w);
    idle(3);
    rd(A_DIV, 8'(cyc - w), "R2 divider clear on write");

    // R9: upper control bits ignored and read as ones
    wr(A_CTL, 8'hF8, w);
    rd(A_CTL, 8'hF8, "R9 control read ones");
    idle(40);
    rd(A_CNT, 8'h00, "R9 R3 upper bits do not enable");
    wr(A_CTL, 8'h03, w);
    rd(A_CTL, 8'hFB, "R9 rate bits readback");

    // R1: unmapped addresses
    rd(8'h08, 8'hFF, "R1 unmapped read 0x08");
    rd(8'h03, 8'hFF, "R1 unmapped read 0x03");
    wr(8'h15, 8'h42, w);
    rd(A_CNT, 8'h00, "R1 unmapped write ignored");
    wr(8'h87, 8'h07, w);
    rd(A_CTL, 8'hFB, "R1 unmapped write leaves control");

    // R11: read data holds between reads
    idle(5);
    chk(bus_rdata === last_rd, "R11 rdata holds", bus_rdata, last_rd);

    // R3 / R4: rates, first-step timing
    run_rate(2'b01, 16, 8'h00, 40, "R4 rate 01 period 16");
    idle(50);
    rd(A_CNT, 8'h02, "R3 counter holds while disabled");
    run_rate(2'b10, 64, 8'h10, 200, "R4 rate 10 period 64");
    run_rate(2'b11, 256, 8'h20, 600, "R4 rate 11 period 256");
    run_rate(2'b00, 1024, 8'h00, 1022, "R4 rate 00 no step at 1023");
    run_rate(2'b00, 1024, 8'h00, 1023, "R4 rate 00 step at 1024");
    run_rate(2'b01, 16, 8'h30, 14, "R4 first step needs full period");

    // R5 / R6 / R7: overflow with reload
    wr(A_MOD, 8'h80, w);
    wr(A_CNT, 8'hFE, w);
    wr(A_CTL, 8'h05, e);
    idle(31);
    chk(irq_pulse === 1'b0, "R6 no pulse before overflow", irq_pulse, 0);
    idle(1);
    chk(irq_pulse === 1'b1, "R6 pulse after overflow edge", irq_pulse, 1);
    chk(irq_pending === 1'b1, "R7 pending set", irq_pending, 1);
    idle(1);
    chk(irq_pulse === 1'b0, "R6 pulse is one cycle", irq_pulse, 0);
    chk(irq_pending === 1'b1, "R7 pending sticky", irq_pending, 1);
    wr(A_CTL, 8'h01, d);
    rd(A_CNT, 8'h80, "R5 reload from modulo");
    irq_ack = 1'b1;
    idle(1);
    irq_ack = 1'b0;
    chk(irq_pending === 1'b0, "R7 ack clears pending", irq_pending, 0);

    // R7: overflow and acknowledge on the same edge
    wr(A_CNT, 8'hFF, w);
    wr(A_CTL, 8'h05, e);
    idle(15);
    irq_ack = 1'b1;
    idle(1);
    irq_ack = 1'b0;
    chk(irq_pending === 1'b1, "R7 set wins over ack", irq_pending, 1);
    chk(irq_pulse === 1'b1, "R6 pulse at race", irq_pulse, 1);
    wr(A_CTL, 8'h01, d);
    irq_ack = 1'b1;
    idle(1);
    irq_ack = 1'b0;
    chk(irq_pending === 1'b0, "R7 cleared again", irq_pending, 0);

    // R8: counter write on the same edge as a step
    wr(A_CNT, 8'hFF, w);
    wr(A_CTL, 8'h05, e);
    idle(15);
    wr(A_CNT, 8'h33, w);
    chk(w == e + 16, "R8 write lands on step edge", w, e + 16);
    chk(irq_pulse === 1'b0, "R8 no overflow pulse", irq_pulse, 0);
    wr(A_CTL, 8'h01, d);
    chk(irq_pending === 1'b0, "R8 no pending", irq_pending, 0);
    rd(A_CNT, 8'h33, "R8 written value wins");

    idle(3);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule